// File: doc/BRIEF.md
# Variable Pulse Width Bus Frame Receiver

This block turns the level history of a single-wire bus into frame bytes. The bus encodes information in how long each level lasts, not in where its edges fall. A frame opens with a long active (high) mark. It then carries data bits, each of which is one pulse of alternating level. A long passive (low) mark ends the data section. An optional in-frame response follows, introduced by a normalization pulse. A low period that lasts long enough closes the frame. The receiver measures each level in microsecond ticks and sorts it into a symbol class. It shifts bits into bytes, most significant bit first, runs a CRC-8 over the data section, and reports each byte as it completes. It also reports the end of each frame, with a CRC verdict, and whether the frame ran past its byte limit.

The caller supplies a bus level that is already synchronized to `clk` (1 = active/high) and a one-cycle strobe once per microsecond. All outputs are registered single-cycle pulses, except `byte_data` and `byte_ifr`, which hold their values between bytes.

Top module: `vpw_frame_rx`

## Requirements
- R1: While reset is held, and after it is released until a frame is received, `byte_valid`, `frame_end`, `crc_err`, `overflow`, `byte_ifr` and `byte_data` are all zero.
- R2: A completed level is classified by its length in ticks. Below 34 is a glitch. 34 to 95 is short. 96 to 162 is long. 163 to 238 is a mark. A high level of 239 or more is a break. A low level that reaches 239 is end of frame.
- R3: Inside a frame, a short low pulse decodes as bit 1, a short high pulse as bit 0, a long low pulse as bit 0, and a long high pulse as bit 1.
- R4: Bits are collected most significant first. After every eighth bit, `byte_valid` pulses for one cycle and `byte_data` carries the byte. In the data section `byte_ifr` is 0.
- R5: A high mark starts a new frame from any state and discards any partial frame. Pulses that arrive outside a frame produce no output.
- R6: A low mark in the data section, followed by a high short or high long pulse (the normalization bit), starts the in-frame response. Bytes from the response are reported with `byte_ifr` = 1.
- R7: When the bus stays low for 239 ticks inside a frame, `frame_end` pulses for exactly one cycle and the receiver returns to idle.
- R8: The CRC register starts at 0xFF. It shifts every data-section bit (not the start mark, not the response) with polynomial 0x1D. At `frame_end`, `crc_err` is 1 if the register differs from 0xC4, or if the data section did not end on a byte boundary. A frame whose last data byte is the inverted CRC of the bytes before it gives `crc_err` = 0.
- R9: A frame holds at most 12 bytes in total, data and response together. When a 13th byte completes, `overflow` pulses instead of `byte_valid`, and the frame is dropped: no later byte and no `frame_end` is reported for it.
- R10: A glitch, a break, or a symbol that does not fit the current frame position drops the frame silently. No further byte and no `frame_end` follow until the next start mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Synchronized bus level, 1 = active |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| byte_valid | output | 1 | A received byte is on `byte_data` |
| byte_data | output | 8 | Last received byte |
| byte_ifr | output | 1 | Last byte came from the in-frame response |
| frame_end | output | 1 | End of frame detected |
| crc_err | output | 1 | Data section CRC check failed (with `frame_end`) |
| overflow | output | 1 | Byte limit exceeded; frame dropped |

## Verification
The bench sends bits at both levels and both widths. A receiver that swaps the short/long meaning for one level would return bytes that differ from those sent. A receiver that shifted least significant bit first would return the bytes reversed. Frames of exactly 12 bytes and of 13 bytes probe the limit: an off-by-one counter either flags a legal frame or lets a thirteenth byte through. A single corrupted byte must raise `crc_err`, and a response byte must not affect the CRC. An error in either case shows up as a false or missing CRC verdict. Glitches, restarts in mid-frame, and bits sent with no start mark must not leak bytes or frame ends. Pulse widths near the window edges (40, 150, 170 and 230 ticks) catch thresholds that have been set at the wrong value.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic [2:0] {
    SYM_GLITCH,
    SYM_SHORT,
    SYM_LONG,
    SYM_MARK,
    SYM_BREAK
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e kind;
    logic      lvl;
  } sym_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_NORM,
    ST_RESP
  } rx_state_e;

endpackage

// File: rtl/vpw_pulse_timer.sv
module vpw_pulse_timer
  import vpw_rx_pkg::*;
#(
  parameter int SHORT_MIN = 34,
  parameter int LONG_MIN  = 96,
  parameter int MARK_MIN  = 163,
  parameter int EOF_MIN   = 239
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic tick,
  output logic sym_valid,
  output sym_t sym,
  output logic eof_hit
);
  localparam int CW = $clog2(EOF_MIN + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_MIN);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_MIN);
  localparam logic [CW-1:0] MARK_L  = CW'(MARK_MIN);
  localparam logic [CW-1:0] SAT_L   = CW'(EOF_MIN);
  localparam logic [CW-1:0] EOF_M1  = CW'(EOF_MIN - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_w;

  assign edge_w = bus_in ^ lvl_q;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_w)                      cnt_d = '0;
    else if (tick && cnt_q != SAT_L) cnt_d = cnt_q + CW'(1);
  end

  always_comb begin
    sym.lvl = lvl_q;
    if (cnt_q < SHORT_L)     sym.kind = SYM_GLITCH;
    else if (cnt_q < LONG_L) sym.kind = SYM_SHORT;
    else if (cnt_q < MARK_L) sym.kind = SYM_LONG;
    else if (cnt_q < SAT_L)  sym.kind = SYM_MARK;
    else                     sym.kind = SYM_BREAK;
  end

  assign sym_valid = edge_w;
  assign eof_hit   = !edge_w && !lvl_q && tick && (cnt_q == EOF_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= bus_in;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/vpw_bit_shifter.sv
module vpw_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word,
  output logic         partial
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [W-2:0]  sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;

  assign done    = en && (idx_q == LAST);
  assign word    = {sh_q, bit_in};
  assign partial = (idx_q != '0);

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (en) begin
      sh_d  = {sh_q[W-3:0], bit_in};
      idx_d = done ? '0 : idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/vpw_crc8.sv
module vpw_crc8 #(
  parameter logic [7:0] POLY = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       en,
  input  logic       bit_in,
  output logic [7:0] crc
);
  logic [7:0] crc_d;
  logic       fb;

  assign fb = crc[7] ^ bit_in;

  always_comb begin
    crc_d = crc;
    if (init)    crc_d = 8'hFF;
    else if (en) crc_d = {crc[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= 8'hFF;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/vpw_frame_rx.sv
module vpw_frame_rx
  import vpw_rx_pkg::*;
#(
  parameter int         SHORT_MIN   = 34,
  parameter int         LONG_MIN    = 96,
  parameter int         MARK_MIN    = 163,
  parameter int         EOF_MIN     = 239,
  parameter int         MAX_BYTES   = 12,
  parameter logic [7:0] CRC_POLY    = 8'h1D,
  parameter logic [7:0] CRC_RESIDUE = 8'hC4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_in,
  input  logic       tick_us,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_ifr,
  output logic       frame_end,
  output logic       crc_err,
  output logic       overflow
);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam logic [BCW-1:0] MAX_L = BCW'(MAX_BYTES);

  logic       sym_valid, eof_hit;
  sym_t       sym;
  logic       bit_w, is_bit;
  logic       sh_clr, sh_en, sh_done, sh_partial;
  logic [7:0] sh_word;
  logic       crc_init, crc_en;
  logic [7:0] crc_w;

  rx_state_e      st_q, st_d;
  logic [BCW-1:0] nbytes_q, nbytes_d;
  logic           part_q, part_d;
  logic           bv_d, ifr_d, fe_d, ce_d, ov_d;
  logic [7:0]     data_d;

  vpw_pulse_timer #(
    .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN),
    .MARK_MIN(MARK_MIN), .EOF_MIN(EOF_MIN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tick(tick_us),
    .sym_valid(sym_valid), .sym(sym), .eof_hit(eof_hit)
  );

  vpw_bit_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .en(sh_en), .bit_in(bit_w),
    .done(sh_done), .word(sh_word), .partial(sh_partial)
  );

  vpw_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .bit_in(bit_w), .crc(crc_w)
  );

  // short/long meaning flips with level
  assign bit_w  = (sym.kind == SYM_SHORT) ^ sym.lvl;
  assign is_bit = (sym.kind == SYM_SHORT) || (sym.kind == SYM_LONG);

  always_comb begin
    st_d     = st_q;
    nbytes_d = nbytes_q;
    part_d   = part_q;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    bv_d     = 1'b0;
    ifr_d    = byte_ifr;
    data_d   = byte_data;
    fe_d     = 1'b0;
    ce_d     = 1'b0;
    ov_d     = 1'b0;
    if (sym_valid && sym.kind == SYM_MARK && sym.lvl) begin
      st_d     = ST_DATA;
      nbytes_d = '0;
      part_d   = 1'b0;
      sh_clr   = 1'b1;
      crc_init = 1'b1;
    end else if (sym_valid) begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_DATA, ST_RESP: begin
          if (is_bit) begin
            sh_en  = 1'b1;
            crc_en = (st_q == ST_DATA);
            if (sh_done) begin
              if (nbytes_q == MAX_L) begin
                ov_d = 1'b1;
                st_d = ST_IDLE;
              end else begin
                bv_d     = 1'b1;
                data_d   = sh_word;
                ifr_d    = (st_q == ST_RESP);
                nbytes_d = nbytes_q + BCW'(1);
              end
            end
          end else if (sym.kind == SYM_MARK && st_q == ST_DATA) begin
            st_d   = ST_NORM;
            part_d = sh_partial;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_NORM: begin
          if (is_bit && sym.lvl) begin
            st_d   = ST_RESP;
            sh_clr = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end else if (eof_hit && st_q != ST_IDLE) begin
      fe_d = 1'b1;
      ce_d = (crc_w != CRC_RESIDUE) || part_q || (st_q == ST_DATA && sh_partial);
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      nbytes_q   <= '0;
      part_q     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_ifr   <= 1'b0;
      frame_end  <= 1'b0;
      crc_err    <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      st_q       <= st_d;
      nbytes_q   <= nbytes_d;
      part_q     <= part_d;
      byte_valid <= bv_d;
      byte_data  <= data_d;
      byte_ifr   <= ifr_d;
      frame_end  <= fe_d;
      crc_err    <= ce_d;
      overflow   <= ov_d;
    end
  end
endmodule

// File: rtl/vpw_frame_rx_chk.sv
module vpw_frame_rx_chk #(
  parameter int MAX_BYTES = 12,
  parameter int BCW       = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_in,
  input logic           byte_valid,
  input logic           frame_end,
  input logic           crc_err,
  input logic           overflow,
  input logic [BCW-1:0] byte_cnt
);
  // R8
  crc_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> frame_end);

  // R7
  frame_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R7
  frame_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !$past(bus_in));

  // R4
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R9
  no_byte_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !byte_valid && !frame_end);

  // R9
  byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(byte_cnt) <= MAX_BYTES);
endmodule

bind vpw_frame_rx vpw_frame_rx_chk #(.MAX_BYTES(MAX_BYTES), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .byte_valid(byte_valid),
  .frame_end(frame_end), .crc_err(crc_err), .overflow(overflow),
  .byte_cnt(nbytes_q)
);

// File: tb/sim_vpw_frame_rx.sv
module sim_vpw_frame_rx;
  logic       clk, rst_n, bus_in, tick_us;
  logic       byte_valid, byte_ifr, frame_end, crc_err, overflow;
  logic [7:0] byte_data;

  int total, bad;
  bit done;
  logic cur_lvl;

  // monitor record
  logic [7:0] mon_b [0:255];
  logic       mon_f [0:255];
  int mon_n, mon_fe, mon_ce, mon_ov;

  logic [7:0] fb [0:15];
  logic [7:0] rb [0:3];

  vpw_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tick_us(tick_us),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ifr(byte_ifr),
    .frame_end(frame_end), .crc_err(crc_err), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    tick_us = 1'b0;
    forever @(negedge clk) tick_us = ~tick_us;
  end

  initial begin
    mon_n = 0; mon_fe = 0; mon_ce = 0; mon_ov = 0;
    forever begin
      @(negedge clk);
      if (byte_valid) begin
        mon_b[mon_n[7:0]] = byte_data;
        mon_f[mon_n[7:0]] = byte_ifr;
        mon_n = mon_n + 1;
      end
      if (frame_end) mon_fe = mon_fe + 1;
      if (crc_err)   mon_ce = mon_ce + 1;
      if (overflow)  mon_ov = mon_ov + 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total = total + 1;
    if (got != exp) begin
      bad = bad + 1;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic logic [7:0] crc_of(input int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) begin
        logic f;
        f = c[7] ^ fb[i][k];
        c = {c[6:0], 1'b0} ^ (f ? 8'h1D : 8'h00);
      end
    return ~c;
  endfunction

  task automatic tx(input logic lvl, input int ticks);
    @(negedge clk);
    bus_in  = lvl;
    cur_lvl = lvl;
    repeat (ticks * 2 - 1) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b, input int sw, input int lw);
    logic l;
    l = ~cur_lvl;
    if (l == 1'b0) tx(l, b ? sw : lw);
    else           tx(l, b ? lw : sw);
  endtask

  task automatic tx_byte(input logic [7:0] v, input int sw, input int lw);
    for (int k = 7; k >= 0; k--) tx_bit(v[k], sw, lw);
  endtask

  // data bytes fb[0..n-1]; resp bytes rb[0..m-1]; nb: 0 none, 1 short, 2 long
  task automatic tx_frame(input int n, input int m, input int nb,
                          input int sw, input int lw, input int mk);
    tx(1'b1, mk);
    for (int i = 0; i < n; i++) tx_byte(fb[i], sw, lw);
    if (nb != 0) begin
      tx(1'b0, mk);
      tx(1'b1, nb == 1 ? 64 : 128);
      for (int i = 0; i < m; i++) tx_byte(rb[i], sw, lw);
    end
    tx(1'b0, 300);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_bytes(input string req, input int base, input int n,
                           input int ifr);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(mon_b[8'(base + i)]), int'(ifr != 0 ? rb[i] : fb[i]));
      chk(req, int'(mon_f[8'(base + i)]), ifr);
    end
  endtask

  task automatic t_reset;
    chk("R1 byte_valid", int'(byte_valid), 0);
    chk("R1 frame_end", int'(frame_end), 0);
    chk("R1 crc_err", int'(crc_err), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 byte_data", int'(byte_data), 0);
    chk("R1 byte_ifr", int'(byte_ifr), 0);
  endtask

  task automatic t_good;
    int b0, f0, c0;
    b0 = mon_n; f0 = mon_fe; c0 = mon_ce;
    fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h01;
    fb[3] = crc_of(3);
    tx_frame(4, 0, 0, 64, 128, 200);
    chk("R4 count", mon_n - b0, 4);
    cmp_bytes("R3 R4 bytes", b0, 4, 0);
    chk("R7 frame_end", mon_fe - f0, 1);
    chk("R8 crc ok", mon_ce - c0, 0);
  endtask

  task automatic t_bad_crc;
    int f0, c0;
    f0 = mon_fe; c0 = mon_ce;
    fb[0] = 8'h10; fb[1] = 8'hFE;
    fb[2] = crc_of(2) ^ 8'h08;
    tx_frame(3, 0, 0, 64, 128, 200);
    chk("R7 frame_end", mon_fe - f0, 1);
    chk("R8 crc bad", mon_ce - c0, 1);
  endtask

  task automatic t_windows;
    int b0, f0, c0;
    b0 = mon_n; f0 = mon_fe; c0 = mon_ce;
    fb[0] = 8'h96; fb[1] = 8'h7E;
    fb[2] = crc_of(2);
    tx_frame(3, 0, 0, 40, 150, 170);
    chk("R2 count", mon_n - b0, 3);
    cmp_bytes("R2 bytes", b0, 3, 0);
    chk("R2 frame_end", mon_fe - f0, 1);
    chk("R2 crc", mon_ce - c0, 0);
  endtask

  task automatic t_resp(input int nb);
    int b0, f0, c0;
    b0 = mon_n; f0 = mon_fe; c0 = mon_ce;
    fb[0] = 8'h48; fb[1] = 8'hC3;
    fb[2] = crc_of(2);
    rb[0] = 8'h5A; rb[1] = 8'h81;
    tx(1'b1, 200);
    for (int i = 0; i < 3; i++) tx_byte(fb[i], 64, 128);
    tx(1'b0, 230);
    tx(1'b1, nb == 1 ? 64 : 128);
    for (int i = 0; i < 2; i++) tx_byte(rb[i], 64, 128);
    tx(1'b0, 300);
    repeat (4) @(negedge clk);
    chk("R6 count", mon_n - b0, 5);
    cmp_bytes("R6 data", b0, 3, 0);
    cmp_bytes("R6 resp", b0 + 3, 2, 1);
    chk("R6 frame_end", mon_fe - f0, 1);
    chk("R8 resp excluded", mon_ce - c0, 0);
  endtask

  task automatic t_max;
    int b0, o0, c0;
    b0 = mon_n; o0 = mon_ov; c0 = mon_ce;
    for (int i = 0; i < 11; i++) fb[i] = 8'(8'h11 * i + 3);
    fb[11] = crc_of(11);
    tx_frame(12, 0, 0, 64, 128, 200);
    chk("R9 twelve ok", mon_n - b0, 12);
    chk("R9 no overflow", mon_ov - o0, 0);
    chk("R8 twelve crc", mon_ce - c0, 0);
  endtask

  task automatic t_over;
    int b0, o0, f0;
    b0 = mon_n; o0 = mon_ov; f0 = mon_fe;
    for (int i = 0; i < 13; i++) fb[i] = 8'(8'h21 + i);
    tx_frame(13, 0, 0, 64, 128, 200);
    chk("R9 bytes kept", mon_n - b0, 12);
    chk("R9 overflow", mon_ov - o0, 1);
    chk("R9 dropped", mon_fe - f0, 0);
  endtask

  task automatic t_no_sof;
    int b0, f0;
    b0 = mon_n; f0 = mon_fe;
    for (int i = 0; i < 2; i++) tx_byte(8'h5F, 64, 128);
    tx(1'b0, 300);
    repeat (4) @(negedge clk);
    chk("R5 no bytes", mon_n - b0, 0);
    chk("R5 no end", mon_fe - f0, 0);
  endtask

  task automatic t_glitch;
    int b0, f0;
    b0 = mon_n; f0 = mon_fe;
    tx(1'b1, 200);
    for (int k = 0; k < 5; k++) tx_bit(1'b1, 64, 128);
    tx(~cur_lvl, 10);
    tx_byte(8'hAA, 64, 128);
    tx(1'b0, 300);
    repeat (4) @(negedge clk);
    chk("R10 no bytes", mon_n - b0, 0);
    chk("R10 no end", mon_fe - f0, 0);
  endtask

  task automatic t_restart;
    int b0, f0, c0;
    b0 = mon_n; f0 = mon_fe; c0 = mon_ce;
    tx(1'b1, 200);
    for (int k = 0; k < 3; k++) tx_bit(1'b0, 64, 128);
    fb[0] = 8'hE7; fb[1] = crc_of(1);
    tx_frame(2, 0, 0, 64, 128, 200);
    chk("R5 restart count", mon_n - b0, 2);
    cmp_bytes("R5 restart bytes", b0, 2, 0);
    chk("R5 restart end", mon_fe - f0, 1);
    chk("R5 restart crc", mon_ce - c0, 0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    bus_in = 1'b0; cur_lvl = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_reset;
    t_good;
    t_bad_crc;
    t_windows;
    t_resp(1);
    t_resp(2);
    t_max;
    t_over;
    t_no_sof;
    t_glitch;
    t_restart;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog got=timeout expected=finish");
      finish_run;
    end
  end
endmodule